// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block keeps wall-clock time and a calendar in seven packed-BCD registers: seconds, minutes, hours, day of month, month, day of week and a two-digit year. A free-running prescaler divides an incoming 32768 Hz enable down to one advance per second. Each advance ripples a carry through the registers. The carry chain handles the length of each month, a 29th day of February in leap years, and both 12-hour and 24-hour hour formats.

A host interface sits beside the block. It loads registers through a single-cycle write port and observes them through a combinational read port. The top bit of the seconds register doubles as a halt control that freezes timekeeping. The top bit of the hours register selects the hour format. Bit 5 of the hours register is the PM flag in 12-hour mode and the twenties bit of the hour tens digit in 24-hour mode.

Register indices, which are also the port addresses: 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 month, 5 day of week, 6 year. Index 7 is unused.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. Seconds 59 rolls to 00 and carries into minutes. Minutes 59 rolls to 00 and carries into hours.
- R2: With hours bit 7 = 0 (24-hour format), hours count 00 to 23, with bit 5 acting as the twenties bit. Hours 23 rolls to 00 and advances the day of month.
- R3: With hours bit 7 = 1 (12-hour format), bits 4:0 hold 01 to 12 and bit 5 is PM. Hour 11 rolls to 12 and toggles PM. Hour 12 rolls to 01 with PM unchanged. The day of month advances only when 11 PM rolls to 12 AM.
- R4: The day of month rolls to 01 after 30 for months 04, 06, 09 and 11, and after 31 for the other months except February. Each such roll advances the month.
- R5: February rolls after 29 when the BCD year value is divisible by 4, and after 28 otherwise.
- R6: The day of week counts 1 to 7, advances whenever the day of month advances, and wraps from 7 to 1. Month 12 rolls to 01 and advances the year, which wraps from 99 to 00.
- R7: While seconds bit 7 = 1, no register advances and the prescaler holds. The bit reads back as written, and writing it to 0 resumes counting.
- R8: Fixed-zero bits always read 0 regardless of the value written: minutes bit 7, hours bit 6, day-of-month bits 7:6, month bits 7:5 and day-of-week bits 7:3. Address 7 reads 0x00 and ignores writes.
- R9: One advance happens per 2^PRESCALE_BITS cycles with tick_32k high. A write to the seconds register clears the prescaler, so the next advance comes a full period later.
- R10: A write that lands in the same cycle as a prescaler wrap takes effect, and the pending advance is applied on the next write-free cycle instead of being lost. A write to seconds discards it.
- R11: After reset the registers read seconds 0x80 (halted), minutes 0x00, hours 0x00, day of month 0x01, month 0x01, day of week 0x01 and year 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable at the 32768 Hz rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register index to write |
| wr_data | input | 8 | Write data, packed BCD |
| rd_addr | input | 3 | Register index to read |
| rd_data | output | 8 | Read data for rd_addr, combinational |

## Verification
The situation hardest to reach from the ports is a host write landing in exactly the cycle the prescaler wraps. Also hard to reach are the rare calendar carries: February 28/29 across all hundred years, and December 31 of year 99. The bench builds the design with a two-bit prescaler so that a second is four ticked cycles. It preloads each boundary time directly through the write port and advances a single second. For the collision, it counts three ticks after a seconds write and issues the next write together with the fourth tick.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
   localparam int NUM_REGS = 7;
   localparam int REG_W    = 8;
   localparam int ADDR_W   = 3;

   localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
   localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
   localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
   localparam logic [ADDR_W-1:0] A_DATE = 3'd3;
   localparam logic [ADDR_W-1:0] A_MON  = 3'd4;
   localparam logic [ADDR_W-1:0] A_DOW  = 3'd5;
   localparam logic [ADDR_W-1:0] A_YEAR = 3'd6;

   typedef logic [NUM_REGS-1:0][REG_W-1:0] reg_bank_t;

   // bits that may hold a one in each register
   function automatic logic [REG_W-1:0] field_mask(input int idx);
      case (idx)
         0:       return 8'hFF;
         1:       return 8'h7F;
         2:       return 8'hBF;
         3:       return 8'h3F;
         4:       return 8'h1F;
         5:       return 8'h07;
         6:       return 8'hFF;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [REG_W-1:0] reset_value(input int idx);
      case (idx)
         0:       return 8'h80;
         3, 4, 5: return 8'h01;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [REG_W-1:0] bcd_inc(input logic [REG_W-1:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // 10*t + u divisible by 4  <=>  2*t[0] + u[1:0] == 0 (mod 4)
   function automatic logic is_leap(input logic [REG_W-1:0] yr);
      logic [1:0] s;
      s = {yr[4], 1'b0} + yr[1:0];
      return (s == 2'b00);
   endfunction

   function automatic logic [REG_W-1:0] month_last(input logic [REG_W-1:0] mon,
                                                   input logic leap);
      case (mon)
         8'h02:                      return leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
   parameter int PRESCALE_BITS = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clear,
   input  logic run,
   output logic sec_pulse
);
   logic [PRESCALE_BITS-1:0] cnt;

   assign sec_pulse = run && tick && (cnt == '1);

   always_ff @(posedge clk) begin
      if (!rst_n)         cnt <= '0;
      else if (clear)     cnt <= '0;
      else if (run && tick) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/rtc_rollover.sv
`timescale 1ns/1ps
module rtc_rollover
   import rtc_cal_pkg::*;
(
   input  reg_bank_t cur,
   output reg_bank_t nxt
);
   logic             c_min, c_hour, c_day, c_mon, c_year;
   logic [REG_W-1:0] s_inc, m_inc, h_val, h_inc, d_inc, w_inc, mo_inc, y_inc, last_day;
   logic             pm_n;

   always_comb begin
      nxt    = cur;
      c_min  = 1'b0;
      c_hour = 1'b0;
      c_day  = 1'b0;
      c_mon  = 1'b0;
      c_year = 1'b0;
      pm_n   = cur[2][5];
      s_inc  = bcd_inc({1'b0, cur[0][6:0]});
      m_inc  = bcd_inc(cur[1]);
      d_inc  = bcd_inc(cur[3]);
      w_inc  = bcd_inc(cur[5]);
      mo_inc = bcd_inc(cur[4]);
      y_inc  = bcd_inc(cur[6]);
      last_day = month_last(cur[4], is_leap(cur[6]));
      h_val  = cur[2][7] ? {3'b000, cur[2][4:0]} : {2'b00, cur[2][5:0]};
      h_inc  = bcd_inc(h_val);

      // seconds, halt bit kept
      if (cur[0][6:0] >= 7'h59) begin
         nxt[0] = {cur[0][7], 7'h00};
         c_min  = 1'b1;
      end else begin
         nxt[0] = {cur[0][7], s_inc[6:0]};
      end

      if (c_min) begin
         if (cur[1] >= 8'h59) begin
            nxt[1] = 8'h00;
            c_hour = 1'b1;
         end else begin
            nxt[1] = m_inc;
         end
      end

      if (c_hour) begin
         if (cur[2][7]) begin
            if (h_val == 8'h11) begin
               pm_n   = ~cur[2][5];
               c_day  = cur[2][5];
               nxt[2] = {2'b10, ~cur[2][5], 5'h12};
            end else if (h_val >= 8'h12) begin
               nxt[2] = {2'b10, pm_n, 5'h01};
            end else begin
               nxt[2] = {2'b10, pm_n, h_inc[4:0]};
            end
         end else begin
            if (h_val >= 8'h23) begin
               nxt[2] = 8'h00;
               c_day  = 1'b1;
            end else begin
               nxt[2] = {2'b00, h_inc[5:0]};
            end
         end
      end

      if (c_day) begin
         nxt[5] = (cur[5] >= 8'h07) ? 8'h01 : w_inc;
         if (cur[3] >= last_day) begin
            nxt[3] = 8'h01;
            c_mon  = 1'b1;
         end else begin
            nxt[3] = d_inc;
         end
      end

      if (c_mon) begin
         if (cur[4] >= 8'h12) begin
            nxt[4] = 8'h01;
            c_year = 1'b1;
         end else begin
            nxt[4] = mo_inc;
         end
      end

      if (c_year) nxt[6] = (cur[6] >= 8'h99) ? 8'h00 : y_inc;
   end
endmodule

// File: rtl/rtc_bcd_calendar.sv
`timescale 1ns/1ps
module rtc_bcd_calendar
   import rtc_cal_pkg::*;
#(
   parameter int PRESCALE_BITS = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_32k,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data
);
   if (PRESCALE_BITS < 1 || PRESCALE_BITS > 24) begin : g_bad_cfg
      $error("rtc_bcd_calendar: PRESCALE_BITS must be within 1..24");
   end

   reg_bank_t regs;
   reg_bank_t nxt;
   logic      halt, sec_wr, sec_pulse, adv_pend, do_adv;

   assign halt   = regs[0][7];
   assign sec_wr = wr_en && (wr_addr == A_SEC);
   assign do_adv = (sec_pulse || adv_pend) && !wr_en && !halt;

   rtc_prescaler #(.PRESCALE_BITS(PRESCALE_BITS)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_32k),
      .clear     (sec_wr),
      .run       (!halt),
      .sec_pulse (sec_pulse)
   );

   rtc_rollover u_roll (
      .cur (regs),
      .nxt (nxt)
   );

   // an advance blocked by a write waits for the next free cycle
   always_ff @(posedge clk) begin
      if (!rst_n)      adv_pend <= 1'b0;
      else if (sec_wr) adv_pend <= 1'b0;
      else if (wr_en)  adv_pend <= adv_pend || sec_pulse;
      else             adv_pend <= 1'b0;
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [REG_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= reset_value(i);
         else if (wr_en && wr_addr == ADDR_W'(i))
            q <= wr_data & field_mask(i);
         else if (do_adv)
            q <= nxt[i];
      end
      assign regs[i] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_REGS; k++)
         if (rd_addr == ADDR_W'(k)) rd_data = regs[k];
   end
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_chk
   import rtc_cal_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              sec_pulse,
   input logic              adv_pend,
   input reg_bank_t         regs
);
   // R7: halted and no write -> whole bank unchanged
   a_r7_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (regs[0][7] && !wr_en) |=> (regs == $past(regs)));

   // R7: no prescaler wrap while halted
   a_r7_no_pulse_halted: assert property (@(posedge clk) disable iff (!rst_n)
      regs[0][7] |-> !sec_pulse);

   // R8: fixed-zero bits stay zero
   a_r8_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (regs[1][7] == 1'b0) && (regs[2][6] == 1'b0) && (regs[3][7:6] == 2'b00) &&
      (regs[4][7:5] == 3'b000) && (regs[5][7:3] == 5'b00000));

   // R9: seconds move without a write only after a wrap or a pending advance
   a_r9_sec_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && regs[0] != $past(regs[0])) |-> ($past(sec_pulse) || $past(adv_pend)));

   // R10: wrap colliding with a non-seconds write is remembered
   a_r10_defer: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_pulse && wr_en && wr_addr != A_SEC) |=> adv_pend);

   // R6: day of week follows every day-of-month change made by counting
   a_r6_dow_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(wr_en) && regs[3] != $past(regs[3])) |-> (regs[5] != $past(regs[5])));
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .sec_pulse (sec_pulse),
   .adv_pend  (adv_pend),
   .regs      (regs)
);

// File: tb/rtc_bcd_calendar_bench.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_bench;
   localparam int PB = 2;
   localparam int SEC_TICKS = 1 << PB;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_32k = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;

   // reference model, plain integers, hour kept 0..23
   int ms, mm, mh, md, mmo, mdw, my;
   bit m12;

   always #2 clk = ~clk;

   rtc_bcd_calendar #(.PRESCALE_BITS(PB)) u_rtc_bcd_calendar (
      .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   function automatic logic [7:0] bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic int dim(input int mo, input int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] enc_hour();
      int h12;
      if (!m12) return bcd(mh);
      h12 = (mh % 12 == 0) ? 12 : mh % 12;
      return 8'h80 | ((mh >= 12) ? 8'h20 : 8'h00) | bcd(h12);
   endfunction

   task automatic m_step();
      ms++;
      if (ms == 60) begin
         ms = 0; mm++;
         if (mm == 60) begin
            mm = 0; mh++;
            if (mh == 24) begin
               mh = 0;
               mdw = (mdw == 7) ? 1 : mdw + 1;
               md++;
               if (md > dim(mmo, my)) begin
                  md = 1; mmo++;
                  if (mmo == 13) begin
                     mmo = 1; my = (my + 1) % 100;
                  end
               end
            end
         end
      end
   endtask

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic tick_n(input int n);
      @(negedge clk);
      tick_32k = 1'b1;
      repeat (n) @(negedge clk);
      tick_32k = 1'b0;
   endtask

   task automatic set_model(input int s, input int m, input int h, input int d,
                            input int mo, input int w, input int y, input bit f12);
      ms = s; mm = m; mh = h; md = d; mmo = mo; mdw = w; my = y; m12 = f12;
   endtask

   task automatic load();
      wr(3'd1, bcd(mm));
      wr(3'd2, enc_hour());
      wr(3'd3, bcd(md));
      wr(3'd4, bcd(mmo));
      wr(3'd5, bcd(mdw));
      wr(3'd6, bcd(my));
      wr(3'd0, bcd(ms));
   endtask

   task automatic check_all(input string req);
      logic [7:0] v;
      rd(3'd0, v); chk(req, "seconds", v, bcd(ms));
      rd(3'd1, v); chk(req, "minutes", v, bcd(mm));
      rd(3'd2, v); chk(req, "hours",   v, enc_hour());
      rd(3'd3, v); chk(req, "date",    v, bcd(md));
      rd(3'd4, v); chk(req, "month",   v, bcd(mmo));
      rd(3'd5, v); chk(req, "dow",     v, bcd(mdw));
      rd(3'd6, v); chk(req, "year",    v, bcd(my));
   endtask

   task automatic one_second(input string req);
      tick_n(SEC_TICKS);
      m_step();
      check_all(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11: reset contents
      rd(3'd0, v); chk("R11", "seconds", v, 8'h80);
      rd(3'd1, v); chk("R11", "minutes", v, 8'h00);
      rd(3'd2, v); chk("R11", "hours",   v, 8'h00);
      rd(3'd3, v); chk("R11", "date",    v, 8'h01);
      rd(3'd4, v); chk("R11", "month",   v, 8'h01);
      rd(3'd5, v); chk("R11", "dow",     v, 8'h01);
      rd(3'd6, v); chk("R11", "year",    v, 8'h00);
      rd(3'd7, v); chk("R8",  "addr7",   v, 8'h00);

      // R1: continuous seconds across a minute and an hour boundary
      set_model(50, 58, 7, 12, 6, 3, 21, 0);
      load();
      for (int i = 0; i < 75; i++) begin
         tick_n(SEC_TICKS);
         m_step();
         rd(3'd0, v); chk("R1", "seconds", v, bcd(ms));
         rd(3'd1, v); chk("R1", "minutes", v, bcd(mm));
         rd(3'd2, v); chk("R1", "hours",   v, enc_hour());
      end

      // R1: every minute value carrying out of second 59
      for (int m = 0; m < 60; m++) begin
         set_model(59, m, 5, 9, 8, 4, 30, 0);
         load();
         one_second("R1");
      end

      // R2: every hour in 24-hour format at xx:59:59
      for (int h = 0; h < 24; h++) begin
         set_model(59, 59, h, 10, 3, 2, 5, 0);
         load();
         one_second("R2");
      end

      // R3: every hour in 12-hour format at xx:59:59
      for (int h = 0; h < 24; h++) begin
         set_model(59, 59, h, 10, 3, 7, 5, 1);
         load();
         one_second("R3");
      end

      // R5: February end in every year
      for (int y = 0; y < 100; y++) begin
         for (int d = 28; d <= 29; d++) begin
            if (d <= dim(2, y)) begin
               set_model(59, 59, 23, d, 2, (y % 7) + 1, y, 0);
               load();
               one_second("R5");
            end
         end
      end

      // R4 / R6: last two days of every other month, year rollover included
      for (int mo = 1; mo <= 12; mo++) begin
         if (mo != 2) begin
            for (int yi = 0; yi < 3; yi++) begin
               int y;
               y = (yi == 0) ? 3 : (yi == 1) ? 4 : 99;
               for (int d = dim(mo, y) - 1; d <= dim(mo, y); d++) begin
                  set_model(59, 59, 23, d, mo, (mo % 7) + 1, y, 0);
                  load();
                  one_second((mo == 12 && d == 31) ? "R6" : "R4");
               end
            end
         end
      end

      // R6: day of week 7 wraps to 1
      set_model(59, 59, 23, 14, 5, 7, 40, 0);
      load();
      one_second("R6");

      // R7: halt freezes, clearing resumes
      set_model(30, 20, 10, 11, 7, 3, 12, 0);
      load();
      wr(3'd0, 8'h80 | bcd(ms));
      tick_n(10 * SEC_TICKS);
      rd(3'd0, v); chk("R7", "halted seconds", v, 8'h80 | bcd(ms));
      rd(3'd1, v); chk("R7", "halted minutes", v, bcd(mm));
      wr(3'd0, bcd(ms));
      one_second("R7");

      // R8: fixed-zero bits and unused address
      wr(3'd1, 8'hFF); rd(3'd1, v); chk("R8", "minutes mask", v, 8'h7F);
      wr(3'd2, 8'hFF); rd(3'd2, v); chk("R8", "hours mask",   v, 8'hBF);
      wr(3'd3, 8'hFF); rd(3'd3, v); chk("R8", "date mask",    v, 8'h3F);
      wr(3'd4, 8'hFF); rd(3'd4, v); chk("R8", "month mask",   v, 8'h1F);
      wr(3'd5, 8'hFF); rd(3'd5, v); chk("R8", "dow mask",     v, 8'h07);
      wr(3'd7, 8'h55); rd(3'd7, v); chk("R8", "addr7 write",  v, 8'h00);
      rd(3'd6, v); chk("R8", "year after addr7 write", v, bcd(my));

      // R9: period length and prescaler clear on seconds write
      set_model(0, 15, 9, 20, 4, 1, 33, 0);
      load();
      tick_n(SEC_TICKS - 1);
      rd(3'd0, v); chk("R9", "before wrap", v, bcd(ms));
      tick_n(1);
      m_step();
      rd(3'd0, v); chk("R9", "at wrap", v, bcd(ms));
      tick_n(SEC_TICKS - 2);
      ms = 5;
      wr(3'd0, bcd(ms));
      tick_n(SEC_TICKS - 1);
      rd(3'd0, v); chk("R9", "after clear, short of period", v, bcd(ms));
      tick_n(1);
      m_step();
      rd(3'd0, v); chk("R9", "after clear, full period", v, bcd(ms));

      // R10: write colliding with the wrap
      set_model(59, 59, 23, 31, 12, 7, 20, 0);
      load();
      tick_n(SEC_TICKS - 1);
      @(negedge clk);
      tick_32k = 1'b1; wr_en = 1'b1; wr_addr = 3'd6; wr_data = bcd(42);
      @(negedge clk);
      tick_32k = 1'b0; wr_en = 1'b0;
      my = 42;
      @(negedge clk);
      m_step();
      check_all("R10");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule